// File: doc/BRIEF.md
# Time-Slot Interchange Switch Core

This block is a nonblocking time and space switch for byte-wide time-division multiplexed highways. Every clock cycle is one time slot. In that cycle the block takes one received byte from each receive highway and stores it in a data memory. In the same cycle it produces one byte for each transmit highway. A connection memory has one word per output slot, and that word decides what the slot carries: a byte switched from any input channel, one of four constant bytes written by the host, or nothing. When a slot carries nothing, its output enable is low and the data lines idle at all ones. Several outputs may name the same source, which broadcasts it.

The data memory has two banks that trade roles at every frame boundary. In frame-integrity mode, an output frame reads only the bank holding the previous complete input frame. In low-latency mode, an output slot whose source slot has already been received in the current frame takes that fresh byte. Every other source comes from the previous frame. Each transmit highway can be set to move 4-bit or 2-bit units instead of whole bytes, with a chosen source unit and destination unit.

Host writes to the connection memory first go to a pending copy. The whole table is copied into the active copy at the end of the frame. The host can read back the pending connection words, the control registers, and the last complete received frame. The default instance has 4 highways of 32 slots each, which gives 128 channels.

Top module: `tsi_switch`

## Requirements
- R1: `cur_slot` counts 0,1,…,31 and wraps from 31 to 0. `frame_sync` is high while `cur_slot` is 0.
- R2: A connection word with mode 00 switches the byte received on highway `word[3:2]`, slot `word[8:4]`, to its output slot. Several outputs may name the same source.
- R3: With register 0 bit 0 clear (frame integrity), every switched byte comes from the input frame before the current one. The two data memory banks swap only after slot 31.
- R4: With register 0 bit 0 set (low latency), a source slot lower than the output slot is taken from the current input frame. Any other source slot is taken from the previous frame.
- R5: Mode 01 sends host byte register `word[5:4]` (addresses 0x004–0x007). Any number of outputs may use the same register.
- R6: Mode 10 or 11 drives `tx_oe` low and `tx_data` to 0xFF for that slot. After reset every entry is in this state.
- R7: Register 1 holds a 2-bit unit size per transmit highway h, in bits [2h+1:2h]: 00 byte, 01 nibble, 10 bit pair. For a subrate highway, source unit `word[10:9]` is moved into destination unit `word[12:11]`. Unit 0 is the least significant, and a nibble uses only the low bit of each position field. All other output bits are 1.
- R8: A connection write (address 0x100 | hwy·32+slot) reads back at once but changes the output only from the next frame on.
- R9: A read at address 0x080 | hwy·32+slot returns that channel's byte from the last complete input frame.
- R10: While reset is held, `tx_oe` is 0, `tx_data` is all ones and `cur_slot` is 0.
- R11: `tx_slot`, `tx_data` and `tx_oe` present the slot that `cur_slot` showed one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_data | input | 32 | Received byte per highway, highway h in bits [8h+7:8h] |
| host_addr | input | 9 | Host address |
| host_wdata | input | 16 | Host write data |
| host_we | input | 1 | Host write strobe |
| host_rdata | output | 16 | Host read data, combinational from `host_addr` |
| cur_slot | output | 5 | Slot being received in this cycle |
| frame_sync | output | 1 | High in slot 0 |
| tx_slot | output | 5 | Slot presented on the transmit outputs |
| tx_data | output | 32 | Transmitted byte per highway |
| tx_oe | output | 4 | Per-highway output enable |

## Verification
The bench aims first at the source-frame choice. In low-latency mode it places sources just below, equal to and above the output slot. A design that compared with the wrong inequality, or read the wrong bank, would send a byte one frame early or one frame late. It then rewrites a connection in the middle of a frame, both at a slot already sent and at one not yet sent. An eager update would change the later slot within the same frame. Subrate placements at the outermost unit positions, broadcast of one source and one host byte, and readback of the last complete frame catch shifted fields, wrong fill bits and a swapped bank.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

  typedef enum logic [1:0] {
    SRC_SWITCH = 2'b00,
    SRC_HOST   = 2'b01,
    SRC_IDLE0  = 2'b10,
    SRC_IDLE1  = 2'b11
  } src_mode_e;

  typedef enum logic [1:0] {
    UNIT_BYTE   = 2'b00,
    UNIT_NIBBLE = 2'b01,
    UNIT_PAIR   = 2'b10,
    UNIT_RSVD   = 2'b11
  } unit_e;

  // Move one subrate unit of a source byte into an all-ones output byte.
  function automatic logic [7:0] fit_unit(input logic [7:0] b, input unit_e u,
                                          input logic [1:0] sp, input logic [1:0] dp);
    logic [7:0] r;
    r = 8'hFF;
    case (u)
      UNIT_NIBBLE: r[{dp[0], 2'b00} +: 4] = b[{sp[0], 2'b00} +: 4];
      UNIT_PAIR:   r[{dp, 1'b0} +: 2]     = b[{sp, 1'b0} +: 2];
      default:     r = b;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/tsi_slot_ctr.sv
module tsi_slot_ctr #(
  parameter int NSLOT = 32,
  localparam int SW = $clog2(NSLOT)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [SW-1:0] slot,
  output logic          last
);
  logic [SW-1:0] slot_nxt;

  assign last = (slot == SW'(NSLOT - 1));

  always_comb begin
    slot_nxt = last ? '0 : slot + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot <= '0;
    else        slot <= slot_nxt;
  end
endmodule

// File: rtl/tsi_data_mem.sv
module tsi_data_mem #(
  parameter int NHWY  = 4,
  parameter int NSLOT = 32,
  localparam int HW   = $clog2(NHWY),
  localparam int SW   = $clog2(NSLOT),
  localparam int IDXW = HW + SW,
  localparam int NCH  = NHWY * NSLOT
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SW-1:0]        wr_slot,
  input  logic [NHWY*8-1:0]    wr_data,
  input  logic                 swap,
  output logic                 wbank,
  input  logic [NHWY-1:0]      rd_cur,
  input  logic [NHWY*IDXW-1:0] rd_idx,
  output logic [NHWY*8-1:0]    rd_data,
  input  logic [IDXW-1:0]      host_idx,
  output logic [7:0]           host_data
);
  logic [7:0] mem [2*NCH];
  logic       wbank_nxt;

  always_comb begin
    wbank_nxt = swap ? ~wbank : wbank;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wbank <= 1'b0;
    else        wbank <= wbank_nxt;
  end

  always_ff @(posedge clk) begin
    for (int h = 0; h < NHWY; h++) begin
      mem[{wbank, HW'(h), wr_slot}] <= wr_data[h*8 +: 8];
    end
  end

  for (genvar p = 0; p < NHWY; p++) begin : g_rd
    assign rd_data[p*8 +: 8] = mem[{rd_cur[p] ? wbank : ~wbank, rd_idx[p*IDXW +: IDXW]}];
  end

  assign host_data = mem[{~wbank, host_idx}];
endmodule

// File: rtl/tsi_conn_mem.sv
module tsi_conn_mem #(
  parameter int NCH   = 128,
  parameter int CW    = 13,
  parameter int NPORT = 4,
  parameter logic [CW-1:0] IDLE = CW'(2),
  localparam int IDXW = $clog2(NCH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [IDXW-1:0]       wr_idx,
  input  logic [CW-1:0]         wr_word,
  input  logic                  commit,
  input  logic [NPORT*IDXW-1:0] rd_idx,
  output logic [NPORT*CW-1:0]   rd_word,
  input  logic [IDXW-1:0]       host_idx,
  output logic [CW-1:0]         host_word
);
  logic [CW-1:0] pend [NCH];
  logic [CW-1:0] act  [NCH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        pend[i] <= IDLE;
        act[i]  <= IDLE;
      end
    end else begin
      if (wr_en) pend[wr_idx] <= wr_word;
      if (commit) begin
        for (int i = 0; i < NCH; i++) act[i] <= pend[i];
      end
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_rd
    assign rd_word[p*CW +: CW] = act[rd_idx[p*IDXW +: IDXW]];
  end

  assign host_word = pend[host_idx];
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
  import tsi_pkg::*;
#(
  parameter int NHWY  = 4,
  parameter int NSLOT = 32,
  parameter int AW    = 9,
  parameter int DW    = 16,
  localparam int HW   = $clog2(NHWY),
  localparam int SW   = $clog2(NSLOT),
  localparam int IDXW = HW + SW,
  localparam int NCH  = NHWY * NSLOT,
  localparam int CW   = IDXW + 6,
  localparam int NHOST = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NHWY*8-1:0] rx_data,
  input  logic [AW-1:0]     host_addr,
  input  logic [DW-1:0]     host_wdata,
  input  logic              host_we,
  output logic [DW-1:0]     host_rdata,
  output logic [SW-1:0]     cur_slot,
  output logic              frame_sync,
  output logic [SW-1:0]     tx_slot,
  output logic [NHWY*8-1:0] tx_data,
  output logic [NHWY-1:0]   tx_oe
);
  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic frame_end;
  tsi_slot_ctr #(.NSLOT(NSLOT)) u_ctr (
    .clk(clk), .rst_n(rst_sync_n), .slot(cur_slot), .last(frame_end)
  );
  assign frame_sync = (cur_slot == '0);

  // Host decode
  logic sel_cm, sel_dm, reg_we;
  logic [2:0] reg_off;
  assign sel_cm  = host_addr[AW-1];
  assign sel_dm  = !host_addr[AW-1] && host_addr[AW-2];
  assign reg_off = host_addr[2:0];
  assign reg_we  = host_we && !sel_cm && !sel_dm;

  logic                       ll_q, ll_nxt;
  logic [2*NHWY-1:0]          sub_q, sub_nxt;
  logic [NHOST-1:0][7:0]      host_q, host_nxt;

  always_comb begin
    ll_nxt   = ll_q;
    sub_nxt  = sub_q;
    host_nxt = host_q;
    if (reg_off == 3'd0)      ll_nxt = host_wdata[0];
    else if (reg_off == 3'd1) sub_nxt = host_wdata[2*NHWY-1:0];
    else if (reg_off[2])      host_nxt[reg_off[1:0]] = host_wdata[7:0];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ll_q   <= 1'b0;
      sub_q  <= '0;
      host_q <= '0;
    end else if (reg_we) begin
      ll_q   <= ll_nxt;
      sub_q  <= sub_nxt;
      host_q <= host_nxt;
    end
  end

  // Memories
  logic [NHWY*IDXW-1:0] cm_rd_idx, dm_rd_idx;
  logic [NHWY*CW-1:0]   cm_word;
  logic [CW-1:0]        cm_host_word;
  logic [NHWY-1:0]      dm_rd_cur;
  logic [NHWY*8-1:0]    dm_rd_data;
  logic [7:0]           dm_host_byte;
  logic                 dm_wbank;

  tsi_conn_mem #(.NCH(NCH), .CW(CW), .NPORT(NHWY), .IDLE(CW'(SRC_IDLE0))) u_cm (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_en(host_we && sel_cm), .wr_idx(host_addr[IDXW-1:0]), .wr_word(host_wdata[CW-1:0]),
    .commit(frame_end),
    .rd_idx(cm_rd_idx), .rd_word(cm_word),
    .host_idx(host_addr[IDXW-1:0]), .host_word(cm_host_word)
  );

  tsi_data_mem #(.NHWY(NHWY), .NSLOT(NSLOT)) u_dm (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_slot(cur_slot), .wr_data(rx_data), .swap(frame_end), .wbank(dm_wbank),
    .rd_cur(dm_rd_cur), .rd_idx(dm_rd_idx), .rd_data(dm_rd_data),
    .host_idx(host_addr[IDXW-1:0]), .host_data(dm_host_byte)
  );

  always_comb begin
    host_rdata = '0;
    if (sel_cm)      host_rdata = DW'(cm_host_word);
    else if (sel_dm) host_rdata = DW'(dm_host_byte);
    else if (reg_off == 3'd0) host_rdata = DW'(ll_q);
    else if (reg_off == 3'd1) host_rdata = DW'(sub_q);
    else if (reg_off[2])      host_rdata = DW'(host_q[reg_off[1:0]]);
  end

  // Output slot formation, one per transmit highway
  logic [NHWY*8-1:0] dat_nxt;
  logic [NHWY-1:0]   oe_nxt;

  for (genvar h = 0; h < NHWY; h++) begin : g_tx
    logic [CW-1:0] w;
    logic [1:0]    md, sp, dp;
    logic [HW-1:0] sh;
    logic [SW-1:0] ss;
    logic [7:0]    src_b;

    assign w  = cm_word[h*CW +: CW];
    assign md = w[1:0];
    assign sh = w[2 +: HW];
    assign ss = w[2+HW +: SW];
    assign sp = w[2+IDXW +: 2];
    assign dp = w[4+IDXW +: 2];

    assign cm_rd_idx[h*IDXW +: IDXW] = {HW'(h), cur_slot};
    assign dm_rd_idx[h*IDXW +: IDXW] = {sh, ss};
    assign dm_rd_cur[h] = ll_q && (ss < cur_slot);

    assign src_b = (md == SRC_HOST) ? host_q[ss[1:0]] : dm_rd_data[h*8 +: 8];
    assign oe_nxt[h] = ~md[1];
    assign dat_nxt[h*8 +: 8] = md[1] ? 8'hFF : fit_unit(src_b, unit_e'(sub_q[2*h +: 2]), sp, dp);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      tx_data <= '1;
      tx_oe   <= '0;
      tx_slot <= '0;
    end else begin
      tx_data <= dat_nxt;
      tx_oe   <= oe_nxt;
      tx_slot <= cur_slot;
    end
  end
endmodule

// File: rtl/tsi_chk.sv
module tsi_chk #(
  parameter int NHWY  = 4,
  parameter int NSLOT = 32,
  localparam int SW   = $clog2(NSLOT)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [SW-1:0]     cur_slot,
  input logic [SW-1:0]     tx_slot,
  input logic [NHWY-1:0]   tx_oe,
  input logic [NHWY*8-1:0] tx_data,
  input logic              wbank
);
  // R1
  slot_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_slot == SW'(NSLOT - 1)) |=> (cur_slot == '0));

  // R1
  slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_slot != SW'(NSLOT - 1)) |=> (cur_slot == SW'($past(cur_slot) + 1'b1)));

  // R11
  tx_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (tx_slot == $past(cur_slot)));

  // R3
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_slot != SW'(NSLOT - 1)) |=> $stable(wbank));

  // R3
  bank_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_slot == SW'(NSLOT - 1)) |=> (wbank != $past(wbank)));

  for (genvar h = 0; h < NHWY; h++) begin : g_idle
    // R6
    idle_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_oe[h] |-> (tx_data[h*8 +: 8] == 8'hFF));
  end
endmodule

bind tsi_switch tsi_chk #(.NHWY(NHWY), .NSLOT(NSLOT)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .cur_slot(cur_slot), .tx_slot(tx_slot),
  .tx_oe(tx_oe), .tx_data(tx_data), .wbank(dm_wbank)
);

// File: tb/tb_tsi_switch.sv
module tb_tsi_switch;
  localparam int NHWY = 4, NSLOT = 32, NCH = 128;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] rx_data;
  logic [8:0]  host_addr;
  logic [15:0] host_wdata;
  logic        host_we;
  logic [15:0] host_rdata;
  logic [4:0]  cur_slot, tx_slot;
  logic        frame_sync;
  logic [31:0] tx_data;
  logic [3:0]  tx_oe;

  always #2.5 clk = ~clk;

  tsi_switch dut (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_we(host_we), .host_rdata(host_rdata),
    .cur_slot(cur_slot), .frame_sync(frame_sync), .tx_slot(tx_slot),
    .tx_data(tx_data), .tx_oe(tx_oe)
  );

  int n_cmp = 0, n_bad = 0;
  int fc = 0, pf = 0, ps = 0;
  bit live = 0, chk_on = 0;
  logic [15:0] m_pend [NCH];
  logic [15:0] m_act  [NCH];
  logic        m_ll = 1'b0;
  logic [7:0]  m_sub = 8'h00;
  logic [7:0]  m_host [4];

  // {destination index, connection word}
  localparam logic [22:0] VEC [0:11] = '{
    {7'd5,   16'h00A4},  // R2 h0 t5  <- h1 s10
    {7'd6,   16'h00A4},  // R2 broadcast of the same source
    {7'd32,  16'h01FC},  // R4 h1 t0  <- h3 s31 (later slot)
    {7'd63,  16'h0000},  // R4 h1 t31 <- h0 s0 (earlier slot)
    {7'd39,  16'h0021},  // R5 host byte 2
    {7'd20,  16'h0021},  // R5 same host byte broadcast
    {7'd21,  16'h0002},  // R6 idle
    {7'd67,  16'h02C0},  // R7 nibble: h0 s12 unit1 -> unit0
    {7'd68,  16'h0811},  // R7 nibble: host 1 unit0 -> unit1
    {7'd105, 16'h1698},  // R7 pair: h2 s9 unit3 -> unit2
    {7'd106, 16'h18FC},  // R7 pair: h3 s15 unit0 -> unit3
    {7'd95,  16'h01F8}   // R4 same slot h2 s31 -> h2 t31
  };

  function automatic logic [7:0] pat(int f, int h, int s);
    int v;
    v = (f * 101) ^ (h * 32) ^ s;
    return v[7:0];
  endfunction

  function automatic logic [7:0] fit(logic [7:0] b, logic [1:0] sz, logic [1:0] sp, logic [1:0] dp);
    logic [7:0] r;
    int w, si, di;
    if (sz == 2'b01) w = 4;
    else if (sz == 2'b10) w = 2;
    else return b;
    si = (w == 4) ? int'(sp[0]) : int'(sp);
    di = (w == 4) ? int'(dp[0]) : int'(dp);
    r = 8'hFF;
    for (int k = 0; k < w; k++) r[di*w + k] = b[si*w + k];
    return r;
  endfunction

  task automatic expect_out(input int f, input int h, input int t,
                            output logic eo, output logic [7:0] ed, output string tg);
    logic [15:0] w;
    logic [7:0]  b;
    logic [1:0]  sz;
    int sh, ss, sf;
    w  = m_act[h*NSLOT + t];
    sz = m_sub[2*h +: 2];
    sh = int'(w[3:2]);
    ss = int'(w[8:4]);
    if (w[1]) begin
      eo = 1'b0; ed = 8'hFF; tg = "R6"; return;
    end
    eo = 1'b1;
    if (w[1:0] == 2'b01) begin
      b = m_host[ss % 4]; tg = "R5";
    end else begin
      sf = (m_ll && ss < t) ? f : f - 1;
      b  = pat(sf, sh, ss);
      tg = m_ll ? "R4" : "R2/R3";
    end
    if (sz != 2'b00) tg = "R7";
    ed = fit(b, sz, w[10:9], w[12:11]);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic host_wr(input logic [8:0] a, input logic [15:0] d);
    @(negedge clk);
    while (cur_slot < 2 || cur_slot > NSLOT - 3) @(negedge clk);
    host_addr = a; host_wdata = d; host_we = 1'b1;
    if (a[8]) m_pend[a[6:0]] = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic host_rd(input logic [8:0] a, output logic [15:0] d);
    @(negedge clk);
    while (cur_slot < 2 || cur_slot > NSLOT - 3) @(negedge clk);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  task automatic wait_bound(input int n);
    repeat (n) begin
      @(negedge clk);
      while (cur_slot != 0) @(negedge clk);
    end
  endtask

  task automatic wait_slot(input int s);
    @(negedge clk);
    while (cur_slot != s) @(negedge clk);
  endtask

  // Per-slot driver and output comparator
  initial begin
    forever begin
      @(negedge clk);
      if (live) begin
        if (chk_on) begin
          check(tx_slot == 5'(ps), "R11", tx_slot, ps);
          for (int h = 0; h < NHWY; h++) begin
            logic eo;
            logic [7:0] ed;
            string tg;
            expect_out(pf, h, ps, eo, ed, tg);
            check(tx_oe[h] == eo && tx_data[h*8 +: 8] == ed, tg,
                  {tx_oe[h], tx_data[h*8 +: 8]}, {eo, ed});
          end
        end
        if (cur_slot == 0) begin
          fc++;
          for (int i = 0; i < NCH; i++) m_act[i] = m_pend[i];
        end
        for (int h = 0; h < NHWY; h++) rx_data[h*8 +: 8] = pat(fc, h, int'(cur_slot));
        pf = fc;
        ps = int'(cur_slot);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    int s0;
    for (int i = 0; i < NCH; i++) begin m_pend[i] = 16'h0002; m_act[i] = 16'h0002; end
    for (int i = 0; i < 4; i++) m_host[i] = 8'h00;
    rst_n = 1'b0; rx_data = '0; host_addr = '0; host_wdata = '0; host_we = 1'b0;
    repeat (4) @(negedge clk);
    // R10 reset state
    check(tx_oe == 4'h0, "R10", tx_oe, 0);
    check(tx_data == 32'hFFFF_FFFF, "R10", tx_data, 32'hFFFF_FFFF);
    check(cur_slot == 5'd0, "R10", cur_slot, 0);
    rst_n = 1'b1; live = 1'b1;

    // Configuration from the vector table
    for (int v = 0; v < 12; v++) host_wr({2'b10, VEC[v][22:16]}, VEC[v][15:0]);
    host_wr(9'h004, 16'h0011); m_host[0] = 8'h11;
    host_wr(9'h005, 16'h005A); m_host[1] = 8'h5A;
    host_wr(9'h006, 16'h00C3); m_host[2] = 8'hC3;
    host_wr(9'h007, 16'h003C); m_host[3] = 8'h3C;
    host_wr(9'h001, 16'h0090); m_sub = 8'h90;

    // R8 immediate readback of pending words
    for (int v = 0; v < 12; v += 4) begin
      host_rd({2'b10, VEC[v][22:16]}, rd);
      check(rd == VEC[v][15:0], "R8", rd, VEC[v][15:0]);
    end

    // R1 wrap and frame_sync
    wait_bound(1);
    #1 check(frame_sync == 1'b1, "R1", frame_sync, 1);
    @(negedge clk);
    check(cur_slot == 5'd1 && frame_sync == 1'b0, "R1", cur_slot, 1);

    // R2, R3, R5, R6, R7 in frame-integrity mode over whole frames
    wait_bound(2);
    chk_on = 1'b1;
    wait_bound(2);
    chk_on = 1'b0;

    // R4 low-latency mode
    host_wr(9'h000, 16'h0001); m_ll = 1'b1;
    wait_bound(1);
    chk_on = 1'b1;
    wait_bound(2);

    // R8 mid-frame rewrite of a later slot (25) and an earlier one (5)
    wait_slot(10);
    host_wr(9'h119, 16'h0018);
    host_wr(9'h105, 16'h0018);
    wait_slot(26);
    check(tx_oe[0] == 1'b0, "R8", tx_oe[0], 0);
    wait_slot(26);
    check(tx_oe[0] == 1'b1 && tx_data[7:0] == pat(fc, 2, 1), "R8", tx_data[7:0], pat(fc, 2, 1));
    wait_bound(1);
    chk_on = 1'b0;

    // R9 data memory readback of the last complete frame
    for (int k = 0; k < 4; k++) begin
      s0 = k * 9 + 3;
      host_rd({2'b01, 2'(k), 5'(s0)}, rd);
      check(rd[7:0] == pat(fc - 1, k, s0), "R9", rd[7:0], pat(fc - 1, k, s0));
    end

    // R6 return entries to idle, back in frame-integrity mode
    host_wr(9'h000, 16'h0000); m_ll = 1'b0;
    host_wr(9'h105, 16'h0003);
    host_wr(9'h127, 16'h0002);
    wait_bound(2);
    chk_on = 1'b1;
    wait_bound(1);
    chk_on = 1'b0;

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule